// File: doc/BRIEF.md
# Self-Recovering Binary-Encoded Control State Machine

This block is a small sequencing controller with three working states: idle, run and done. It sits in the control path of a larger design. A synchronous start request moves it out of idle, a synchronous finish request ends the run phase, and the done phase lasts exactly one cycle before the machine falls back to idle. The state register uses a two-bit binary code. The all-zero code is a real state: it is both the state after reset and the safe idle state.

The one unused code is never a dead end. Whenever the register holds it, an illegal-state flag is raised for that cycle, and the next clock edge returns the machine to the all-zero idle code whatever the request inputs are doing. A saturating 16-bit diagnostic counter records every entry into the all-zero code, so recovery events show up as extra counts during test. A test hook lets a testbench load any code into the state register, so the recovery path can be exercised on purpose.

Top module: `recov_fsm`

## Requirements
- R1: While rst_n is low, at each clock edge the state goes to code 00 and the visit counter goes to 0, regardless of every other input. The state codes are idle = 2'b00, run = 2'b10 and done = 2'b01.
- R2: In idle (00), start_i high moves the state to run (10) at the next edge; with start_i low the state stays 00, and finish_i has no effect.
- R3: In run (10), finish_i high moves the state to done (01) at the next edge; with finish_i low the state stays 10, and start_i has no effect.
- R4: Done (01) returns to idle (00) at the next edge, whatever start_i and finish_i are.
- R5: illegal_o is high exactly while the state register holds the unused code 2'b11, in the same cycle and with no register delay.
- R6: From code 11, the next edge always loads 00. The state never stays at 11 and never moves to any other code, whatever start_i and finish_i are.
- R7: No transition that starts from a legal code produces code 11 unless the test hook forces it.
- R8: busy_o is high exactly while the state is run (10).
- R9: visits_o increases by exactly one at each edge where the state changes from a nonzero code to 00. It is unchanged at every other edge, including edges where the state stays at 00.
- R10: visits_o saturates at 16'hFFFF and stays there on further entries into 00.
- R11: With force_en_i high and rst_n high, the next edge loads force_code_i into the state register, overriding start_i, finish_i and the normal next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, synchronous to clk |
| finish_i | input | 1 | Finish request, synchronous to clk |
| force_en_i | input | 1 | Test hook: load force_code_i at the next edge |
| force_code_i | input | 2 | Code to load when force_en_i is high |
| state_o | output | 2 | Current state register value |
| busy_o | output | 1 | High while in run |
| illegal_o | output | 1 | High while the state holds an unused code |
| visits_o | output | 16 | Saturating count of entries into code 00 |

## Verification
The assertions assume that start_i, finish_i and the force inputs are stable around each rising edge, and that code 11 only ever arrives through the test hook. For that reason the properties on normal transitions and on the no-illegal rule hold only in cycles where force_en_i is low. The bench changes every input one time unit after a rising edge and never puts an input in an unknown state. It drives code 11 only through force_en_i, and it releases the hook in the following cycle so the recovery edge can be observed. The saturation case is reached by repeating the force-then-recover pair until the counter reaches its limit.

// File: rtl/recov_pkg.sv
// Shared widths and state codes for the self-recovering controller.
// Assumes a two-bit binary state register in which 00 is the safe idle code.
package recov_pkg;
    localparam int ST_W = 2;
    localparam logic [ST_W-1:0] ST_IDLE = 2'b00;
    localparam logic [ST_W-1:0] ST_RUN  = 2'b10;
    localparam logic [ST_W-1:0] ST_DONE = 2'b01;
endpackage

// File: rtl/recov_next.sv
// Next-state logic. Every code that is not a defined state maps to
// ST_IDLE, so the unused code never holds or leads to another unused code.
// Assumes start_i and finish_i are already synchronous to the clock.
module recov_next
    import recov_pkg::*;
(
    input  logic [ST_W-1:0] cur_i,
    input  logic            start_i,
    input  logic            finish_i,
    output logic [ST_W-1:0] nxt_o
);
    // Transition table with an explicit recovery arm
    always_comb begin
        case (cur_i)
            ST_IDLE: nxt_o = start_i  ? ST_RUN  : ST_IDLE;
            ST_RUN:  nxt_o = finish_i ? ST_DONE : ST_RUN;
            ST_DONE: nxt_o = ST_IDLE;
            default: nxt_o = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/recov_decode.sv
// Output decode from the state register: busy in run, and a flag for
// any code outside the defined set. Purely combinational.
module recov_decode
    import recov_pkg::*;
(
    input  logic [ST_W-1:0] cur_i,
    output logic            busy_o,
    output logic            illegal_o
);
    // Flag codes that match no defined state; raise busy only in run
    always_comb begin
        busy_o    = (cur_i == ST_RUN);
        illegal_o = (cur_i != ST_IDLE) && (cur_i != ST_RUN) && (cur_i != ST_DONE);
    end
endmodule

// File: rtl/recov_visit_cnt.sv
// Saturating event counter. It counts one per cycle with bump_i high and
// holds at all-ones. Synchronous active-low reset clears it.
module recov_visit_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Count events, stopping at the maximum value
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (bump_i && (cnt_o != CNT_MAX))
            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/recov_fsm.sv
// Self-recovering control state machine: idle -> run -> done -> idle.
// Its unused code returns to the all-zero idle code on the next edge.
// A saturating counter records each entry into code 00, and a test hook
// can load any code. Assumes synchronous inputs; reset is synchronous and
// active low.
module recov_fsm
    import recov_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             finish_i,
    input  logic             force_en_i,
    input  logic [ST_W-1:0]  force_code_i,
    output logic [ST_W-1:0]  state_o,
    output logic             busy_o,
    output logic             illegal_o,
    output logic [CNT_W-1:0] visits_o
);
    logic [ST_W-1:0] state_q;
    logic [ST_W-1:0] fsm_nxt;
    logic [ST_W-1:0] state_d;
    logic            enter_zero;

    recov_next u_next (
        .cur_i    (state_q),
        .start_i  (start_i),
        .finish_i (finish_i),
        .nxt_o    (fsm_nxt)
    );

    // Test hook overrides the normal next state
    always_comb begin
        state_d    = force_en_i ? force_code_i : fsm_nxt;
        enter_zero = (state_d == ST_IDLE) && (state_q != ST_IDLE);
    end

    // State register, reset to the safe idle code
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    recov_decode u_dec (
        .cur_i     (state_q),
        .busy_o    (busy_o),
        .illegal_o (illegal_o)
    );

    recov_visit_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .bump_i (enter_zero),
        .cnt_o  (visits_o)
    );

    assign state_o = state_q;
endmodule

// File: rtl/recov_fsm_chk.sv
// Property checker for recov_fsm, attached with bind. Assumes inputs are
// stable at clock edges and that code 11 arrives only via the test hook.
module recov_fsm_chk
    import recov_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             finish_i,
    input logic             force_en_i,
    input logic [ST_W-1:0]  force_code_i,
    input logic [ST_W-1:0]  state_o,
    input logic             busy_o,
    input logic             illegal_o,
    input logic [CNT_W-1:0] visits_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R2
    start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_IDLE && start_i && !force_en_i) |=> (state_o == ST_RUN));
    // R3
    finish_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_RUN && finish_i && !force_en_i) |=> (state_o == ST_DONE));
    // R4
    done_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_DONE && !force_en_i) |=> (state_o == ST_IDLE));
    // R6
    recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o && !force_en_i) |=> (state_o == ST_IDLE));
    // R7
    no_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!illegal_o && !force_en_i) |=> !illegal_o);
    // R8
    busy_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !illegal_o);
    // R9
    entry_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != ST_IDLE && visits_o != CNT_MAX)
        |=> ((state_o == ST_IDLE) == (visits_o == $past(visits_o) + 1'b1)));
    // R9
    idle_hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_IDLE) |=> (visits_o == $past(visits_o)));
    // R10
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (visits_o == CNT_MAX) |=> (visits_o == CNT_MAX));
    // R11
    force_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_en_i |=> (state_o == $past(force_code_i)));
endmodule

bind recov_fsm recov_fsm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .finish_i     (finish_i),
    .force_en_i   (force_en_i),
    .force_code_i (force_code_i),
    .state_o      (state_o),
    .busy_o       (busy_o),
    .illegal_o    (illegal_o),
    .visits_o     (visits_o)
);

// File: tb/sim_recov_fsm.sv
// Directed bench for recov_fsm: one task per scenario.
module sim_recov_fsm;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        finish_i = 1'b0;
    logic        force_en_i = 1'b0;
    logic [1:0]  force_code_i = 2'b00;
    logic [1:0]  state_o;
    logic        busy_o;
    logic        illegal_o;
    logic [15:0] visits_o;

    int checks = 0;
    int fails  = 0;
    int exp_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    recov_fsm u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .finish_i     (finish_i),
        .force_en_i   (force_en_i),
        .force_code_i (force_code_i),
        .state_o      (state_o),
        .busy_o       (busy_o),
        .illegal_o    (illegal_o),
        .visits_o     (visits_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input bit s, input bit f, input bit fe, input logic [1:0] fc);
        start_i = s; finish_i = f; force_en_i = fe; force_code_i = fc;
    endtask

    task automatic chk_state(input logic [1:0] exp, input string req);
        check(state_o === exp, req, int'(state_o), int'(exp));
    endtask

    task automatic chk_cnt(input string req);
        check(visits_o === 16'(exp_cnt), req, int'(visits_o), exp_cnt);
    endtask

    // R1: reset dominates all inputs
    task automatic t_reset();
        rst_n = 1'b0;
        drive(1, 1, 1, 2'b11);
        step(); step();
        chk_state(2'b00, "R1 reset state");
        exp_cnt = 0;
        chk_cnt("R1 reset count");
        check(busy_o === 1'b0, "R1 busy", int'(busy_o), 0);
        check(illegal_o === 1'b0, "R1 illegal", int'(illegal_o), 0);
        drive(0, 0, 0, 2'b00);
        rst_n = 1'b1;
    endtask

    // R2 R3 R4 R7 R8 R9: normal cycle through the legal states
    task automatic t_flow();
        drive(0, 1, 0, 2'b00); step();
        chk_state(2'b00, "R2 idle holds, finish ignored");
        chk_cnt("R9 no count while staying idle");
        drive(1, 0, 0, 2'b00); step();
        chk_state(2'b10, "R2 start to run");
        check(busy_o === 1'b1, "R8 busy in run", int'(busy_o), 1);
        check(illegal_o === 1'b0, "R7 legal path", int'(illegal_o), 0);
        drive(1, 0, 0, 2'b00); step();
        chk_state(2'b10, "R3 run holds, start ignored");
        drive(0, 1, 0, 2'b00); step();
        chk_state(2'b01, "R3 finish to done");
        check(busy_o === 1'b0, "R8 not busy in done", int'(busy_o), 0);
        check(illegal_o === 1'b0, "R7 legal path", int'(illegal_o), 0);
        drive(1, 1, 0, 2'b00); step();
        chk_state(2'b00, "R4 done returns to idle");
        exp_cnt++;
        chk_cnt("R9 count on done to idle");
        drive(0, 0, 0, 2'b00);
    endtask

    // R5 R6 R9 R11: forced unused code recovers in one edge
    task automatic t_illegal();
        drive(0, 0, 1, 2'b11); step();
        chk_state(2'b11, "R11 force 11");
        check(illegal_o === 1'b1, "R5 illegal flag", int'(illegal_o), 1);
        check(busy_o === 1'b0, "R8 not busy on 11", int'(busy_o), 0);
        chk_cnt("R9 no count entering 11 from 00");
        drive(1, 1, 0, 2'b00); step();
        chk_state(2'b00, "R6 recover to 00");
        check(illegal_o === 1'b0, "R5 flag clears", int'(illegal_o), 1'b0);
        exp_cnt++;
        chk_cnt("R9 count on recovery");
        drive(0, 0, 0, 2'b00);
    endtask

    // R11 R9: force overrides normal transitions
    task automatic t_force_override();
        drive(0, 0, 1, 2'b01); step();
        chk_state(2'b01, "R11 force 01 from idle");
        chk_cnt("R9 leaving 00 no count");
        drive(0, 0, 1, 2'b10); step();
        chk_state(2'b10, "R11 force 10 over done return");
        drive(0, 1, 1, 2'b10); step();
        chk_state(2'b10, "R11 force holds run over finish");
        drive(0, 0, 1, 2'b00); step();
        chk_state(2'b00, "R11 force 00");
        exp_cnt++;
        chk_cnt("R9 forced entry counts");
        drive(0, 0, 0, 2'b00);
    endtask

    // R10: saturation of the visit counter
    task automatic t_saturate();
        for (int i = 0; i < 65540; i++) begin
            drive(0, 0, 1, 2'b11); step();
            drive(0, 0, 0, 2'b00); step();
            if (exp_cnt < 65535) exp_cnt++;
        end
        chk_cnt("R10 saturated value");
        check(state_o === 2'b00, "R6 recover after loop", int'(state_o), 0);
        drive(0, 0, 1, 2'b01); step();
        drive(0, 0, 0, 2'b00); step();
        chk_cnt("R10 stays at max");
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_flow();
        t_illegal();
        t_force_override();
        t_flow();
        t_saturate();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule